// File: doc/BRIEF.md
# Single-Bit Shifter with Left Barrel Rotator

This block is the shift section of a 16-bit arithmetic unit. It acts only on the A operand. It produces either a single-bit shift or a single-bit rotate through the carry flag. As an alternative, it produces a left rotation of the whole word by 0 to 15 places. The second operand of the surrounding ALU never reaches it.

The direction of a single-bit operation comes from the datapath's shared plus/minus control. The same line selects subtraction in the adder, and here a low level means left and a high level means right. An arithmetic control selects sign replication on right shifts, and a through-carry control turns a shift into a rotate through the carry. A rotate-enable control, with its own amount field, switches the block to the barrel rotator. The result and the carry-out are registered, so they appear one clock after the inputs are presented.

Top module: `shift_rot_unit`

## Requirements
- R1: While rst_n is low, y_out and c_out are both 0.
- R2: y_out and c_out reflect the inputs sampled at the previous rising clock edge (one cycle latency).
- R3: With rot_en=0, minus=0 and thru_c=0 (logical left shift), y_out is A shifted left by one with 0 entering bit 0, and c_out is the old bit 15.
- R4: With rot_en=0, minus=1, thru_c=0 and arith=0 (logical right shift), y_out is A shifted right by one with 0 entering bit 15, and c_out is the old bit 0.
- R5: With rot_en=0, minus=1, thru_c=0 and arith=1 (arithmetic right shift), bit 15 is replicated into bits 15 and 14, the rest shifts right by one, and c_out is the old bit 0.
- R6: With rot_en=0, minus=0 and thru_c=1 (rotate left through carry), c_in enters bit 0 and the old bit 15 goes to c_out.
- R7: With rot_en=0, minus=1 and thru_c=1 (rotate right through carry), c_in enters bit 15 and the old bit 0 goes to c_out.
- R8: The arith control has no effect when minus=0 or thru_c=1. An arithmetic left shift equals the logical left shift.
- R9: With rot_en=1, y_out is A rotated left by rot_amt places (0 to 15), and c_out equals c_in.
- R10: With rot_en=1 and rot_amt=0, y_out equals A unchanged.
- R11: rot_en=1 overrides minus, arith and thru_c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 16 | A operand |
| c_in | input | 1 | Carry-in |
| arith | input | 1 | 1 = arithmetic right shift |
| minus | input | 1 | Direction: 0 left, 1 right |
| thru_c | input | 1 | 1 = rotate through carry instead of shift |
| rot_en | input | 1 | 1 = barrel rotate left |
| rot_amt | input | 4 | Barrel rotate amount |
| y_out | output | 16 | Registered result |
| c_out | output | 1 | Registered carry-out |

## Verification
Each mode is tried with alternating-bit words, with words that have only the top bit or only the bottom bit set, and with random words. This separates a fill of 0 from a fill with the sign bit or with the carry, and a carry taken from bit 15 from one taken from bit 0. Both carry-in levels are applied in every mode. A carry that leaks into the plain shifts then shows, and so does a barrel rotate that alters the flag. All sixteen rotate amounts are swept with a one-hot word and with a lopsided word, which exposes any barrel stage that is wired to the wrong amount bit. The ignored controls are then set to every value while the output is watched.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W = 16,
  localparam int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a_in,
  input  logic          c_in,
  input  logic          arith,
  input  logic          minus,
  input  logic          thru_c,
  input  logic          rot_en,
  input  logic [AW-1:0] rot_amt,
  output logic [W-1:0]  y_out,
  output logic          c_out
);

  logic [W-1:0] stage [AW+1];
  assign stage[0] = a_in;

  genvar s;
  generate
    for (s = 0; s < AW; s++) begin : g_rot
      localparam int SH = 1 << s;
      assign stage[s+1] = rot_amt[s]
        ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
        : stage[s];
    end
  endgenerate

  logic         fill_r;
  logic [W-1:0] one_y;
  logic         one_c;

  assign fill_r = thru_c ? c_in : (arith & a_in[W-1]);

  always_comb begin
    if (minus) begin
      one_y = {fill_r, a_in[W-1:1]};
      one_c = a_in[0];
    end else begin
      one_y = {a_in[W-2:0], thru_c & c_in};
      one_c = a_in[W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out <= '0;
      c_out <= 1'b0;
    end else if (rot_en) begin
      y_out <= stage[AW];
      c_out <= c_in;
    end else begin
      y_out <= one_y;
      c_out <= one_c;
    end
  end

endmodule

module shift_rot_unit_chk #(
  parameter int W = 16,
  localparam int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  a_in,
  input logic          c_in,
  input logic          arith,
  input logic          minus,
  input logic          thru_c,
  input logic          rot_en,
  input logic [AW-1:0] rot_amt,
  input logic [W-1:0]  y_out,
  input logic          c_out
);

  logic primed;
  always_ff @(posedge clk) primed <= rst_n;

  always @(negedge clk)
    if (!rst_n) assert_reset_R1: assert (y_out == '0 && c_out == 1'b0);

  assert_shl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!rot_en && !minus && !thru_c) |->
      y_out == {$past(a_in[W-2:0]), 1'b0} && c_out == $past(a_in[W-1]));

  assert_shr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!rot_en && minus && !thru_c && !arith) |->
      y_out == {1'b0, $past(a_in[W-1:1])} && c_out == $past(a_in[0]));

  assert_ashr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!rot_en && minus && !thru_c && arith) |->
      y_out[W-1] == $past(a_in[W-1]) && y_out[W-2] == $past(a_in[W-1]));

  assert_rolc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!rot_en && !minus && thru_c) |->
      y_out[0] == $past(c_in) && c_out == $past(a_in[W-1]));

  assert_rorc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!rot_en && minus && thru_c) |->
      y_out[W-1] == $past(c_in) && c_out == $past(a_in[0]));

  assert_rot_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(rot_en) |-> c_out == $past(c_in));

  assert_rot_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(rot_en && rot_amt == '0) |-> y_out == $past(a_in));

  assert_rot_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(rot_en) |-> $countones(y_out) == $countones($past(a_in)));

endmodule

bind shift_rot_unit shift_rot_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .c_in(c_in), .arith(arith),
  .minus(minus), .thru_c(thru_c), .rot_en(rot_en), .rot_amt(rot_amt),
  .y_out(y_out), .c_out(c_out)
);

// File: tb/sim_shift_rot_unit.sv
`timescale 1ns/1ps
module sim_shift_rot_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] a_in = '0;
  logic        c_in = 0, arith = 0, minus = 0, thru_c = 0, rot_en = 0;
  logic [3:0]  rot_amt = '0;
  logic [15:0] y_out;
  logic        c_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct { logic [16:0] exp; string tag; } item_t;
  item_t q[$];

  shift_rot_unit u0 (.*);

  always #4 clk = ~clk;

  function automatic logic [16:0] model(logic [15:0] a, logic c, logic ar,
      logic mi, logic tc, logic re, logic [3:0] amt);
    logic [31:0] d;
    if (re) begin
      d = {a, a} << amt;
      return {c, d[31:16]};
    end
    if (!mi) return {a[15], a[14:0], tc ? c : 1'b0};
    if (tc)  return {a[0], c, a[15:1]};
    if (ar)  return {a[0], a[15], a[15:1]};
    return {a[0], 1'b0, a[15:1]};
  endfunction

  task automatic drive(logic [15:0] a, logic c, logic ar, logic mi, logic tc,
      logic re, logic [3:0] amt, string tag);
    item_t it;
    @(negedge clk);
    a_in = a; c_in = c; arith = ar; minus = mi; thru_c = tc;
    rot_en = re; rot_amt = amt;
    it.exp = model(a, c, ar, mi, tc, re, amt);
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      compared++;
      if ({c_out, y_out} !== it.exp) begin
        mismatched++;
        $display("FAIL %s: got c=%b y=%h, expected c=%b y=%h",
                 it.tag, c_out, y_out, it.exp[16], it.exp[15:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    a_in = 16'hFFFF; c_in = 1; minus = 1; thru_c = 1;
    repeat (3) @(negedge clk);
    compared++;
    if (y_out !== 16'h0 || c_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: got c=%b y=%h, expected c=0 y=0000", c_out, y_out);
    end
    rst_n = 1;
    for (int c = 0; c < 2; c++) begin
      drive(16'hAAAA, c[0], 0, 0, 0, 0, 0, "R3 shl");
      drive(16'h8001, c[0], 0, 0, 0, 0, 0, "R3 shl");
      drive(16'h5555, c[0], 0, 1, 0, 0, 0, "R4 shr");
      drive(16'h8001, c[0], 0, 1, 0, 0, 0, "R4 shr");
      drive(16'h8001, c[0], 1, 1, 0, 0, 0, "R5 ashr");
      drive(16'h4002, c[0], 1, 1, 0, 0, 0, "R5 ashr");
      drive(16'h8000, c[0], 0, 0, 1, 0, 0, "R6 rolc");
      drive(16'h7FFF, c[0], 0, 0, 1, 0, 0, "R6 rolc");
      drive(16'h0001, c[0], 0, 1, 1, 0, 0, "R7 rorc");
      drive(16'hFFFE, c[0], 0, 1, 1, 0, 0, "R7 rorc");
      drive(16'hC003, c[0], 1, 0, 0, 0, 0, "R8 ashl");
      drive(16'hC003, c[0], 1, 0, 1, 0, 0, "R8 arith+rolc");
      drive(16'hC003, c[0], 1, 1, 1, 0, 0, "R8 arith+rorc");
    end
    for (int k = 0; k < 16; k++) begin
      drive(16'h0001, k[0], 0, 0, 0, 1, k[3:0], "R9 rot one-hot");
      drive(16'h1F3D, ~k[0], 0, 0, 0, 1, k[3:0], "R9 rot");
    end
    drive(16'hBEEF, 1, 0, 0, 0, 1, 0, "R10 rot zero");
    drive(16'h1234, 0, 1, 1, 1, 1, 0, "R10 rot zero");
    for (int m = 0; m < 8; m++)
      drive(16'h8421, m[0], m[1], m[2], m[0], 1, 4'd5, "R11 rot override");
    drive(16'h0F0F, 1, 0, 0, 0, 0, 0, "R2 latency a");
    drive(16'hF0F0, 0, 0, 1, 0, 0, 0, "R2 latency b");
    for (int i = 0; i < 2000; i++)
      drive($urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, "R2 random");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule